// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds the 64-bit control registers that privileged code in a processor core uses for trap state, interrupt priority, processor mode, address-space numbers and exception bookkeeping. A six-bit index selects a register. The block has one combinational read port and one write port that takes effect on the clock edge. Each register has its own write mask and its own access class. The bank stores only the bits that the mask keeps, so every read returns a canonical value without further masking.

Some registers behave in a special way. A write to either exception register clears it. A write to the counter-control register stores the value one. The cycle-count register returns its stored upper half joined with the low half of a tick counter that runs freely inside the block. A read-only register ignores writes. A write-only register cannot be read back. An index that is not assigned is illegal for both reads and writes. Every illegal access raises a one-cycle fault pulse in the same cycle as the strobe that caused it.

Top module: `crb_ctrl_bank`

## Requirements
- R1: After synchronous active-low reset every register reads zero, and `fault` is low while no strobe is active.
- R2: Indices 0 to 3 are scratch registers. They store all 64 written bits. A write is visible from the cycle after its strobe. A read of the same index in the strobe cycle returns the old value. `rd_data` is zero whenever `rd_en` is low.
- R3: The trap-address register (index 4) stores the written value with bit 1 forced to zero.
- R4: The field masks are as follows. Trap request and trap enable (5, 6) keep bits 3:0. Priority level (7) keeps bits 4:0. Current mode and alternate mode (8, 9) keep bits 4:3. Software request (10) keeps the mask 0x7FFF0. Fetch-side address-space number (15) keeps 0x7F0. Data-side address-space number (16) keeps bits 63:57.
- R5: Any write to the exception summary (11) or the exception mask (12) clears that register to zero.
- R6: Indices 17 to 21 are read-only. They read normally. A write to one of them raises `fault` and leaves the register unchanged.
- R7: Indices 22 to 25 are write-only. A write to one of them is accepted without a fault. A read of one of them raises `fault` and returns zero.
- R8: Indices 26 to 63 are unassigned. A read or a write to any of them raises `fault`, a read returns zero, and no register changes.
- R9: A read of the cycle-count register (13) returns the stored bits 63:32 and, in bits 31:0, a tick counter. The tick counter is zero in reset and increases by one on each clock edge after reset. A write to index 13 stores all 64 bits.
- R10: A write of any value to the counter-control register (14) stores the value 1.
- R11: `fault` is combinational. It is high only in a cycle where an active strobe makes an illegal access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read strobe |
| rd_idx | input | 6 | Read register index |
| rd_data | output | 64 | Read value (combinational) |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 6 | Write register index |
| wr_data | input | 64 | Write value |
| fault | output | 1 | Illegal-access pulse |

## Verification
The bench writes all-ones to every index. This exposes a register whose mask is too wide or too narrow: stray bits would read back, or kept bits would be lost. It reads and writes the same index in one cycle, which catches a design that forwards the new value, or one that latches the read. It sends strobes to read-only, write-only and unassigned indices. A design that mis-classed any of these would either miss the fault pulse, or let a write change a register that should hold. The bench follows the cycle-count register from reset. An off-by-one in the tick counter, or a merge that took the stored low half, would show up on every read of index 13.

// File: rtl/crb_pkg.sv
// Package: shared index map, access classes and write masks for the
// control register bank. Assumes 64-bit registers and a 6-bit index.
package crb_pkg;
    localparam int IDX_W     = 6;
    localparam int DATA_W    = 64;
    localparam int HALF_W    = DATA_W / 2;
    localparam int SLOT_CNT  = 26;

    localparam logic [IDX_W-1:0] IX_TRAP_PC   = 6'd4;
    localparam logic [IDX_W-1:0] IX_TRAP_REQ  = 6'd5;
    localparam logic [IDX_W-1:0] IX_TRAP_EN   = 6'd6;
    localparam logic [IDX_W-1:0] IX_PRIO      = 6'd7;
    localparam logic [IDX_W-1:0] IX_MODE_CUR  = 6'd8;
    localparam logic [IDX_W-1:0] IX_MODE_ALT  = 6'd9;
    localparam logic [IDX_W-1:0] IX_SW_REQ    = 6'd10;
    localparam logic [IDX_W-1:0] IX_EXC_SUM   = 6'd11;
    localparam logic [IDX_W-1:0] IX_EXC_MSK   = 6'd12;
    localparam logic [IDX_W-1:0] IX_CYC_CNT   = 6'd13;
    localparam logic [IDX_W-1:0] IX_CYC_CTL   = 6'd14;
    localparam logic [IDX_W-1:0] IX_ASN_FETCH = 6'd15;
    localparam logic [IDX_W-1:0] IX_ASN_DATA  = 6'd16;
    localparam logic [IDX_W-1:0] IX_RO_FIRST  = 6'd17;
    localparam logic [IDX_W-1:0] IX_RO_LAST   = 6'd21;
    localparam logic [IDX_W-1:0] IX_WO_FIRST  = 6'd22;
    localparam logic [IDX_W-1:0] IX_WO_LAST   = 6'd25;

    typedef enum logic [2:0] {
        AC_PLAIN,   // masked store, readable
        AC_CLEAR,   // any write clears
        AC_SET1,    // any write stores one
        AC_RDONLY,  // writes fault
        AC_WRONLY,  // reads fault
        AC_NONE     // unassigned index
    } acc_e;

    // Access class of an index.
    function automatic acc_e acc_class(input logic [IDX_W-1:0] ix);
        if (ix >= IDX_W'(SLOT_CNT))                      return AC_NONE;
        if (ix >= IX_WO_FIRST && ix <= IX_WO_LAST)       return AC_WRONLY;
        if (ix >= IX_RO_FIRST && ix <= IX_RO_LAST)       return AC_RDONLY;
        if (ix == IX_EXC_SUM || ix == IX_EXC_MSK)        return AC_CLEAR;
        if (ix == IX_CYC_CTL)                            return AC_SET1;
        return AC_PLAIN;
    endfunction

    // Bits kept on a write to an index of class PLAIN or WRONLY.
    function automatic logic [DATA_W-1:0] wr_mask(input logic [IDX_W-1:0] ix);
        case (ix)
            IX_TRAP_PC:               return ~64'h2;
            IX_TRAP_REQ, IX_TRAP_EN:  return 64'hF;
            IX_PRIO:                  return 64'h1F;
            IX_MODE_CUR, IX_MODE_ALT: return 64'h18;
            IX_SW_REQ:                return 64'h7FFF0;
            IX_ASN_FETCH:             return 64'h7F0;
            IX_ASN_DATA:              return 64'hFE00_0000_0000_0000;
            default:                  return '1;
        endcase
    endfunction
endpackage

// File: rtl/crb_decode.sv
// Module: index decoder for both ports. Gives the read-side class and the
// cycle-count flag, and the write-side class and mask.
// Assumes: indices are plain binary; no registered state.
module crb_decode
    import crb_pkg::*;
(
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [IDX_W-1:0]  wr_idx,
    output acc_e              rd_cls,
    output logic              rd_is_cyc,
    output acc_e              wr_cls,
    output logic [DATA_W-1:0] wr_msk
);
    // Purpose: classify both indices.
    always_comb begin
        rd_cls    = acc_class(rd_idx);
        rd_is_cyc = (rd_idx == IX_CYC_CNT);
        wr_cls    = acc_class(wr_idx);
        wr_msk    = wr_mask(wr_idx);
    end
endmodule

// File: rtl/crb_tick.sv
// Module: free-running tick counter feeding the low half of cycle-count reads.
// Assumes: wraps silently at its width; synchronous active-low reset.
module crb_tick #(
    parameter int TICK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [TICK_W-1:0] tick
);
    // Purpose: count every clock after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) tick <= '0;
        else        tick <= tick + TICK_W'(1);
    end

    // R9: counter steps by exactly one per cycle
    p_tick_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> tick == $past(tick) + TICK_W'(1));
endmodule

// File: rtl/crb_store.sv
// Module: register storage, one flop row per assigned slot.
// Assumes: the write value is already masked; one write per cycle.
module crb_store #(
    parameter int SLOTS = 26,
    parameter int IW    = 6,
    parameter int DW    = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wval,
    output logic [DW-1:0] slot_q [SLOTS]
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        // Purpose: load slot g when the write targets it.
        always_ff @(posedge clk) begin
            if (!rst_n)                           slot_q[g] <= '0;
            else if (we && widx == IW'(g))        slot_q[g] <= wval;
        end
    end
endmodule

// File: rtl/crb_ctrl_bank.sv
// Module: top of the control register bank. Joins decode, storage and tick
// counter, forms the fault pulse and the read value.
// Assumes: single read and single write port; reads see pre-edge state.
module crb_ctrl_bank
    import crb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [5:0]        rd_idx,
    output logic [63:0]       rd_data,
    input  logic              wr_en,
    input  logic [5:0]        wr_idx,
    input  logic [63:0]       wr_data,
    output logic              fault
);
    acc_e              rd_cls, wr_cls;
    logic              rd_is_cyc;
    logic [DATA_W-1:0] wr_msk;
    logic [HALF_W-1:0] tick;
    logic [DATA_W-1:0] slot_q [SLOT_CNT];
    logic              wr_ok;
    logic [DATA_W-1:0] wr_val;
    logic [DATA_W-1:0] rd_raw;
    logic              rd_bad, wr_bad;

    crb_decode u_dec (
        .rd_idx(rd_idx), .wr_idx(wr_idx),
        .rd_cls(rd_cls), .rd_is_cyc(rd_is_cyc),
        .wr_cls(wr_cls), .wr_msk(wr_msk)
    );

    crb_tick #(.TICK_W(HALF_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    crb_store #(.SLOTS(SLOT_CNT), .IW(IDX_W), .DW(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(wr_ok), .widx(wr_idx),
        .wval(wr_val), .slot_q(slot_q)
    );

    // Purpose: choose the stored value per write class.
    always_comb begin
        wr_ok  = 1'b0;
        wr_val = '0;
        case (wr_cls)
            AC_PLAIN, AC_WRONLY: begin wr_ok = wr_en; wr_val = wr_data & wr_msk; end
            AC_CLEAR:            begin wr_ok = wr_en; wr_val = '0; end
            AC_SET1:             begin wr_ok = wr_en; wr_val = DATA_W'(1); end
            default:             begin wr_ok = 1'b0;  wr_val = '0; end
        endcase
    end

    // Purpose: fetch the addressed slot, zero for unassigned indices.
    always_comb begin
        rd_raw = '0;
        for (int i = 0; i < SLOT_CNT; i++)
            if (rd_idx == IDX_W'(i)) rd_raw = slot_q[i];
    end

    // Purpose: legality of each strobe.
    always_comb begin
        rd_bad = (rd_cls == AC_WRONLY) || (rd_cls == AC_NONE);
        wr_bad = (wr_cls == AC_RDONLY) || (wr_cls == AC_NONE);
    end

    // Purpose: read value and fault pulse.
    always_comb begin
        if (!rd_en || rd_bad) rd_data = '0;
        else if (rd_is_cyc)   rd_data = {rd_raw[DATA_W-1:HALF_W], tick};
        else                  rd_data = rd_raw;
        fault = (rd_en && rd_bad) || (wr_en && wr_bad);
    end

    // R3: stored trap address never holds bit 1
    p_trap_bit1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q[IX_TRAP_PC][1] == 1'b0);
    // R4: mode register holds nothing outside bits 4:3
    p_mode_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q[IX_MODE_CUR] & ~64'h18) == '0);
    // R5: exception summary reads zero after a write
    p_exc_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_idx == IX_EXC_SUM |=> slot_q[IX_EXC_SUM] == '0);
    // R6: a write to a read-only slot leaves it unchanged
    p_ro_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_idx == IX_RO_FIRST |=> $stable(slot_q[IX_RO_FIRST]));
    // R7: a read of a write-only slot faults and returns zero
    p_wo_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rd_idx == IX_WO_FIRST |-> fault && rd_data == '0);
    // R10: counter-control holds one after a write
    p_ctl_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_idx == IX_CYC_CTL |=> slot_q[IX_CYC_CTL] == DATA_W'(1));
    // R11: no fault without a strobe
    p_fault_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en && !wr_en |-> !fault);
endmodule

// File: tb/crb_ctrl_bank_tb_top.sv
module crb_ctrl_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [5:0]  rd_idx = '0, wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;
    logic        fault;

    int vec_n = 0, bad_n = 0;
    bit done = 0;

    logic [63:0]    m [64];
    longint unsigned tk = 0;

    always #5 clk = ~clk;

    crb_ctrl_bank dut_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_idx(rd_idx),
        .rd_data(rd_data), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .fault(fault)
    );

    function automatic bit is_ro(int ix);   return ix >= 17 && ix <= 21; endfunction
    function automatic bit is_wo(int ix);   return ix >= 22 && ix <= 25; endfunction
    function automatic bit is_none(int ix); return ix >= 26;             endfunction

    function automatic logic [63:0] after_wr(int ix, logic [63:0] d, logic [63:0] old);
        case (ix)
            4:       return d & ~64'h2;
            5, 6:    return d & 64'hF;
            7:       return d & 64'h1F;
            8, 9:    return d & 64'h18;
            10:      return d & 64'h7FFF0;
            11, 12:  return 64'h0;
            14:      return 64'h1;
            15:      return d & 64'h7F0;
            16:      return d & 64'hFE00_0000_0000_0000;
            default: return (is_ro(ix) || is_none(ix)) ? old : d;
        endcase
    endfunction

    function automatic string tag_of(int ix);
        if (ix <= 3)  return "R2";
        if (ix == 4)  return "R3";
        if (ix == 11 || ix == 12) return "R5";
        if (ix == 13) return "R9";
        if (ix == 14) return "R10";
        if (is_ro(ix)) return "R6";
        if (is_wo(ix)) return "R7";
        if (is_none(ix)) return "R8";
        return "R4";
    endfunction

    // Reference model state update on each edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) m[i] = '0;
            tk = 0;
        end else begin
            if (wr_en) m[wr_idx] = after_wr(int'(wr_idx), wr_data, m[wr_idx]);
            tk = tk + 1;
        end
    end

    // Compare outputs against the model mid-cycle.
    always @(negedge clk) begin
        logic [63:0] er;
        logic        ef;
        string       ft;
        if (rst_n && !done) begin
            er = '0;
            if (rd_en && !is_wo(int'(rd_idx)) && !is_none(int'(rd_idx))) begin
                if (rd_idx == 6'd13) er = {m[13][63:32], tk[31:0]};
                else                 er = m[rd_idx];
            end
            ef = (rd_en && (is_wo(int'(rd_idx)) || is_none(int'(rd_idx)))) ||
                 (wr_en && (is_ro(int'(wr_idx)) || is_none(int'(wr_idx))));
            vec_n++;
            if (rd_data !== er) begin
                bad_n++;
                $display("FAIL %s rd_data idx %0d: got %h exp %h",
                         rd_en ? tag_of(int'(rd_idx)) : "R2", rd_idx, rd_data, er);
            end
            vec_n++;
            if (fault !== ef) begin
                bad_n++;
                if (wr_en && is_ro(int'(wr_idx)))       ft = "R6";
                else if (rd_en && is_wo(int'(rd_idx)))  ft = "R7";
                else if (ef)                            ft = "R8";
                else                                    ft = "R11";
                $display("FAIL %s fault: got %b exp %b", ft, fault, ef);
            end
        end
    end

    task automatic cyc(input logic re, input int ri, input logic we,
                       input int wi, input logic [63:0] wd);
        @(posedge clk); #1;
        rd_en = re; rd_idx = 6'(ri); wr_en = we; wr_idx = 6'(wi); wr_data = wd;
    endtask

    task automatic idle();
        cyc(1'b0, 0, 1'b0, 0, '0);
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad_n++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        vec_n++;
        if (fault !== 1'b0 || rd_data !== '0) begin // R1 during reset
            bad_n++;
            $display("FAIL R1 reset outputs: got %b/%h exp 0/0", fault, rd_data);
        end
        rst_n = 1'b1;
        // R1: every register reads zero after reset
        for (int i = 0; i < 32; i++) cyc(1'b1, i, 1'b0, 0, '0);
        // R2-R10: write all ones everywhere, then read back
        for (int i = 0; i < 26; i++) cyc(1'b0, 0, 1'b1, i, '1);
        for (int i = 0; i < 26; i++) cyc(1'b1, i, 1'b0, 0, '0);
        // R2: same-cycle read returns old value
        cyc(1'b1, 1, 1'b1, 1, 64'h0123_4567_89AB_CDEF);
        cyc(1'b1, 1, 1'b0, 0, '0);
        // R9: cycle count merge
        cyc(1'b0, 0, 1'b1, 13, 64'hDEAD_BEEF_1234_5678);
        cyc(1'b1, 13, 1'b0, 0, '0);
        cyc(1'b1, 13, 1'b0, 0, '0);
        // R10: counter control with zero data
        cyc(1'b0, 0, 1'b1, 14, '0);
        cyc(1'b1, 14, 1'b0, 0, '0);
        // R8: unassigned indices both ways
        cyc(1'b1, 40, 1'b1, 63, '1);
        cyc(1'b1, 26, 1'b1, 26, '1);
        // R6/R7 with write and read together
        cyc(1'b1, 23, 1'b1, 19, 64'h55);
        cyc(1'b1, 19, 1'b0, 0, '0);
        idle();
        // R11: strobes with no illegal access
        cyc(1'b1, 3, 1'b1, 7, 64'hFFFF);
        // mixed traffic
        for (int k = 0; k < 4000; k++)
            cyc(1'($urandom), int'($urandom_range(0, 31)), 1'($urandom),
                int'($urandom_range(0, 31)), {$urandom, $urandom});
        idle();
        @(posedge clk); #1;
        finish_run();
    end
endmodule